// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers every reset request of a small microcontroller-style chip and turns them into three reset outputs. The system reset goes to the core logic. The power reset marks events that also clear the power-related state. The backup-domain reset goes to the always-on domain. The request sources are:

- a software reset request from the processor;
- completion strobes for the standby and stop low-power entry sequences;
- a force-option-load request;
- a power-on/power-down detector and a standby-exit event;
- a backup software reset level;
- presence flags for the main and battery supplies.

The block also passes each low-power entry through as a one-cycle go pulse when its configuration bit allows normal entry.

Every request input, apart from the two configuration bits and the flag-clear input, passes through a multi-flop synchronizer. Each reset output is held by a stretch counter, so it stays high for at least a parameterised number of cycles after the last request that triggered it. The backup domain ignores ordinary power resets. It is reset only by its own software level, or when a supply returns after both the main and battery supplies were off. A sticky cause register records which kind of event last reset each domain, and software clears it with a clear strobe.

Top module: `rst_ctrl`

## Requirements
- R1: A one-cycle `sw_rst_req` pulse drives `sys_rst` high for exactly MIN_WIDTH (16) consecutive cycles. `sys_rst` first reads high after the third rising clock edge that follows the pulse being driven. `pwr_rst` and `bkp_rst` stay low.
- R2: With `opt_stdby_keep` = 0, a `stdby_enter` strobe produces a 16-cycle `sys_rst` and no `stdby_go` pulse.
- R3: With `opt_stop_keep` = 0, a `stop_enter` strobe produces a 16-cycle `sys_rst` and no `stop_go` pulse.
- R4: With the matching keep bit at 1, a `stdby_enter` or `stop_enter` strobe produces exactly one cycle of `stdby_go` or `stop_go`, and no reset output rises.
- R5: An `obl_force` pulse produces a 16-cycle `sys_rst` and leaves `pwr_rst` low.
- R6: A `por_evt` or `stdby_exit` pulse drives both `pwr_rst` and `sys_rst` high for 16 cycles and leaves `bkp_rst` low. `pwr_rst` is never high without `sys_rst`.
- R7: `bkp_rst` is high for the whole time `bkp_sw_rst` is held, and for MIN_WIDTH-1 further cycles after it drops, so a hold of H cycles gives H+15 high cycles. `sys_rst` and `pwr_rst` stay low.
- R8: When `vdd_on` and `vbat_on` have both been low and either one rises, `bkp_rst` goes high for 16 cycles. A loss and return of one supply while the other stays present gives no `bkp_rst`.
- R9: A new request during an active reset restarts the stretch. A second `sw_rst_req` pulse 5 cycles after the first gives 21 consecutive high cycles of `sys_rst`.
- R10: `cause_flags` bits are sticky. Bit 0 is software, bit 1 standby-entry reset, bit 2 stop-entry reset, bit 3 option load, bit 4 power event and bit 5 backup. They are set in the cycle the matching reset first rises. A `clr_flags` cycle clears them all, and a cause that is set in the same cycle as the clear wins over it.
- R11: While and after `rst` is asserted, all reset outputs, go pulses and `cause_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high initialisation of the controller |
| sw_rst_req | input | 1 | Processor software reset request |
| stdby_enter | input | 1 | Standby entry sequence completed |
| stop_enter | input | 1 | Stop entry sequence completed |
| opt_stdby_keep | input | 1 | 1: standby entry proceeds; 0: standby entry resets |
| opt_stop_keep | input | 1 | 1: stop entry proceeds; 0: stop entry resets |
| obl_force | input | 1 | Force option reload |
| por_evt | input | 1 | Power-on/power-down detector event |
| stdby_exit | input | 1 | Wake from standby event |
| bkp_sw_rst | input | 1 | Backup software reset level |
| vdd_on | input | 1 | Main supply present |
| vbat_on | input | 1 | Battery supply present |
| clr_flags | input | 1 | Clear all cause flags |
| sys_rst | output | 1 | System reset |
| pwr_rst | output | 1 | Power reset |
| bkp_rst | output | 1 | Backup-domain reset |
| stdby_go | output | 1 | Standby entry permitted pulse |
| stop_go | output | 1 | Stop entry permitted pulse |
| cause_flags | output | 6 | Sticky reset cause bits |

## Verification
The bench counts every high cycle of each output around a request, so a stretcher that is one cycle short or one cycle long shows up as a wrong count, and a second request that fails to reload the counter shows up as 16 cycles instead of 21. Each low-power strobe is tested with its keep bit both set and clear. A design with an inverted or swapped option sense would reset where it should emit a go pulse, or the reverse. The supply checks drop one rail alone and then both rails, so a backup reset wired to either rail's edge, or to the power event, would give a spurious `bkp_rst`. A clear timed to land in the same edge as a new cause catches a clear that wrongly takes priority.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // request vector positions after synchronisation
  localparam int REQ_SW   = 0;
  localparam int REQ_SBY  = 1;
  localparam int REQ_STP  = 2;
  localparam int REQ_OBL  = 3;
  localparam int REQ_POR  = 4;
  localparam int REQ_SEX  = 5;
  localparam int REQ_BKP  = 6;
  localparam int REQ_VDD  = 7;
  localparam int REQ_VBAT = 8;
  localparam int NREQ     = 9;

  // sticky cause flag positions
  localparam int CF_SW  = 0;
  localparam int CF_SBY = 1;
  localparam int CF_STP = 2;
  localparam int CF_OBL = 3;
  localparam int CF_PWR = 4;
  localparam int CF_BKP = 5;
  localparam int NCF    = 6;

  // reset output lanes
  localparam int LN_SYS = 0;
  localparam int LN_PWR = 1;
  localparam int LN_BKP = 2;
  localparam int NLANE  = 3;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else if (i == 0) chain[i] <= din;
      else chain[i] <= chain[(i == 0) ? 0 : i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int MIN_WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic rst_out
);
  localparam int CW = $clog2(MIN_WIDTH + 1);
  localparam logic [CW-1:0] LOAD = CW'(MIN_WIDTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_out <= 1'b0;
    end else if (trig) begin
      cnt     <= LOAD;
      rst_out <= 1'b1;
    end else if (cnt > ONE) begin
      cnt     <= cnt - ONE;
      rst_out <= 1'b1;
    end else begin
      cnt     <= '0;
      rst_out <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sw_rst_req,
  input  logic           stdby_enter,
  input  logic           stop_enter,
  input  logic           opt_stdby_keep,
  input  logic           opt_stop_keep,
  input  logic           obl_force,
  input  logic           por_evt,
  input  logic           stdby_exit,
  input  logic           bkp_sw_rst,
  input  logic           vdd_on,
  input  logic           vbat_on,
  input  logic           clr_flags,
  output logic           sys_rst,
  output logic           pwr_rst,
  output logic           bkp_rst,
  output logic           stdby_go,
  output logic           stop_go,
  output logic [NCF-1:0] cause_flags
);
  // supplies read as present while the controller itself is initialised
  localparam logic [NREQ-1:0] SYNC_INIT = NREQ'((1 << REQ_VDD) | (1 << REQ_VBAT));

  logic [NREQ-1:0] req_raw, req_s;
  logic            both_off;
  logic            t_sw, t_sby, t_stp, t_obl, t_pwr, t_bkp;
  logic [NLANE-1:0] lane_trig, lane_out;
  logic [NCF-1:0]  cause_set;

  assign req_raw[REQ_SW]   = sw_rst_req;
  assign req_raw[REQ_SBY]  = stdby_enter;
  assign req_raw[REQ_STP]  = stop_enter;
  assign req_raw[REQ_OBL]  = obl_force;
  assign req_raw[REQ_POR]  = por_evt;
  assign req_raw[REQ_SEX]  = stdby_exit;
  assign req_raw[REQ_BKP]  = bkp_sw_rst;
  assign req_raw[REQ_VDD]  = vdd_on;
  assign req_raw[REQ_VBAT] = vbat_on;

  rstc_sync #(.W(NREQ), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_INIT)) u_sync (
    .clk(clk), .rst(rst), .din(req_raw), .dout(req_s)
  );

  // remembers that both rails were gone at once
  always_ff @(posedge clk) begin
    if (rst) both_off <= 1'b0;
    else     both_off <= ~req_s[REQ_VDD] & ~req_s[REQ_VBAT];
  end

  always_comb begin
    t_sw  = req_s[REQ_SW];
    t_sby = req_s[REQ_SBY] & ~opt_stdby_keep;
    t_stp = req_s[REQ_STP] & ~opt_stop_keep;
    t_obl = req_s[REQ_OBL];
    t_pwr = req_s[REQ_POR] | req_s[REQ_SEX];
    t_bkp = req_s[REQ_BKP] | (both_off & (req_s[REQ_VDD] | req_s[REQ_VBAT]));

    lane_trig[LN_SYS] = t_sw | t_sby | t_stp | t_obl | t_pwr;
    lane_trig[LN_PWR] = t_pwr;
    lane_trig[LN_BKP] = t_bkp;

    cause_set         = '0;
    cause_set[CF_SW]  = t_sw;
    cause_set[CF_SBY] = t_sby;
    cause_set[CF_STP] = t_stp;
    cause_set[CF_OBL] = t_obl;
    cause_set[CF_PWR] = t_pwr;
    cause_set[CF_BKP] = t_bkp;
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    rstc_stretch #(.MIN_WIDTH(MIN_WIDTH)) u_str (
      .clk(clk), .rst(rst), .trig(lane_trig[l]), .rst_out(lane_out[l])
    );
  end

  assign sys_rst = lane_out[LN_SYS];
  assign pwr_rst = lane_out[LN_PWR];
  assign bkp_rst = lane_out[LN_BKP];

  always_ff @(posedge clk) begin
    if (rst) begin
      stdby_go    <= 1'b0;
      stop_go     <= 1'b0;
      cause_flags <= '0;
    end else begin
      stdby_go    <= req_s[REQ_SBY] & opt_stdby_keep;
      stop_go     <= req_s[REQ_STP] & opt_stop_keep;
      cause_flags <= (clr_flags ? '0 : cause_flags) | cause_set;
    end
  end
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk #(
  parameter int MIN_WIDTH = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       opt_stdby_keep,
  input logic       opt_stop_keep,
  input logic       bkp_sw_rst,
  input logic       clr_flags,
  input logic       sys_rst,
  input logic       pwr_rst,
  input logic       bkp_rst,
  input logic       stdby_go,
  input logic       stop_go,
  input logic [5:0] cause_flags
);
  localparam int RW = $clog2(MIN_WIDTH + 2) + 1;
  logic [RW-1:0] run_sys, run_bkp;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_sys <= '0;
      run_bkp <= '0;
    end else begin
      run_sys <= sys_rst ? ((run_sys == '1) ? run_sys : run_sys + 1'b1) : '0;
      run_bkp <= bkp_rst ? ((run_bkp == '1) ? run_bkp : run_bkp + 1'b1) : '0;
    end
  end

  // R1 / R9: system reset never shorter than the minimum width
  p_sys_width_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> (run_sys >= RW'(MIN_WIDTH)));

  // R8: backup reset never shorter than the minimum width
  p_bkp_width_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(bkp_rst) |-> (run_bkp >= RW'(MIN_WIDTH)));

  // R6: power reset always accompanied by system reset
  p_pwr_implies_sys_r6: assert property (@(posedge clk) disable iff (rst)
    pwr_rst |-> sys_rst);

  // R4: go pulses only when the keep option allowed entry
  p_stdby_go_r4: assert property (@(posedge clk) disable iff (rst)
    stdby_go |-> $past(opt_stdby_keep));
  p_stop_go_r4: assert property (@(posedge clk) disable iff (rst)
    stop_go |-> $past(opt_stop_keep));

  // R10: flags only drop after a clear strobe
  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_flags) |-> ((cause_flags & $past(cause_flags)) == $past(cause_flags)));

  // R7: a held backup software level shows on bkp_rst three edges later
  p_bkp_level_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(bkp_sw_rst, 3) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
      |-> bkp_rst);
endmodule

bind rst_ctrl rst_ctrl_chk #(.MIN_WIDTH(MIN_WIDTH)) u_chk (
  .clk(clk), .rst(rst), .opt_stdby_keep(opt_stdby_keep), .opt_stop_keep(opt_stop_keep),
  .bkp_sw_rst(bkp_sw_rst), .clr_flags(clr_flags), .sys_rst(sys_rst), .pwr_rst(pwr_rst),
  .bkp_rst(bkp_rst), .stdby_go(stdby_go), .stop_go(stop_go), .cause_flags(cause_flags)
);

// File: tb/rst_ctrl_tb.sv
module rst_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_rst_req = 0, stdby_enter = 0, stop_enter = 0;
  logic opt_stdby_keep = 0, opt_stop_keep = 0;
  logic obl_force = 0, por_evt = 0, stdby_exit = 0, bkp_sw_rst = 0;
  logic vdd_on = 1, vbat_on = 1, clr_flags = 0;
  logic sys_rst, pwr_rst, bkp_rst, stdby_go, stop_go;
  logic [5:0] cause_flags;

  int checks = 0;
  int errors = 0;
  int c_sys, c_pwr, c_bkp, c_sgo, c_pgo;

  always #10 clk = ~clk;

  rst_ctrl u_dut (
    .clk(clk), .rst(rst), .sw_rst_req(sw_rst_req), .stdby_enter(stdby_enter),
    .stop_enter(stop_enter), .opt_stdby_keep(opt_stdby_keep), .opt_stop_keep(opt_stop_keep),
    .obl_force(obl_force), .por_evt(por_evt), .stdby_exit(stdby_exit),
    .bkp_sw_rst(bkp_sw_rst), .vdd_on(vdd_on), .vbat_on(vbat_on), .clr_flags(clr_flags),
    .sys_rst(sys_rst), .pwr_rst(pwr_rst), .bkp_rst(bkp_rst), .stdby_go(stdby_go),
    .stop_go(stop_go), .cause_flags(cause_flags)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit order: 0 sw, 1 standby, 2 stop, 3 option load, 4 por, 5 standby exit, 6 backup sw
  task automatic set_req(input logic [6:0] m);
    sw_rst_req = m[0]; stdby_enter = m[1]; stop_enter = m[2]; obl_force = m[3];
    por_evt = m[4]; stdby_exit = m[5]; bkp_sw_rst = m[6];
  endtask

  task automatic count_window(input int n);
    c_sys = 0; c_pwr = 0; c_bkp = 0; c_sgo = 0; c_pgo = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      c_sys += int'(sys_rst); c_pwr += int'(pwr_rst); c_bkp += int'(bkp_rst);
      c_sgo += int'(stdby_go); c_pgo += int'(stop_go);
    end
  endtask

  task automatic apply(input logic [6:0] m, input int hold);
    @(negedge clk);
    fork
      begin set_req(m); repeat (hold) @(negedge clk); set_req('0); end
      count_window(50);
    join
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_flags = 1; @(negedge clk); clr_flags = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk); #1;
    check("R11 sys", int'(sys_rst), 0);
    check("R11 pwr", int'(pwr_rst), 0);
    check("R11 bkp", int'(bkp_rst), 0);
    check("R11 flags", int'(cause_flags), 0);
    @(negedge clk); rst = 0;
    repeat (4) @(posedge clk); #1;
    check("R11 after release", int'({sys_rst, pwr_rst, bkp_rst, stdby_go, stop_go}), 0);
  endtask

  task automatic t_sw();
    @(negedge clk); sw_rst_req = 1; @(negedge clk); sw_rst_req = 0;
    @(posedge clk); #1; check("R1 low after 2 edges", int'(sys_rst), 0);
    @(posedge clk); #1; check("R1 high after 3 edges", int'(sys_rst), 1);
    repeat (30) @(posedge clk);
    clear_flags();
    apply(7'b0000001, 1);
    check("R1 sys width", c_sys, 16);
    check("R1 pwr", c_pwr, 0);
    check("R1 bkp", c_bkp, 0);
    check("R10 sw flag", int'(cause_flags), 1);
    clear_flags(); #1;
    check("R10 clear", int'(cause_flags), 0);
  endtask

  task automatic t_lp_reset();
    opt_stdby_keep = 0; opt_stop_keep = 0;
    apply(7'b0000010, 1);
    check("R2 sys width", c_sys, 16);
    check("R2 no go", c_sgo, 0);
    check("R10 standby flag", int'(cause_flags), 2);
    clear_flags();
    apply(7'b0000100, 1);
    check("R3 sys width", c_sys, 16);
    check("R3 no go", c_pgo, 0);
    check("R10 stop flag", int'(cause_flags), 4);
    clear_flags();
  endtask

  task automatic t_keep();
    @(negedge clk); opt_stdby_keep = 1; opt_stop_keep = 1;
    apply(7'b0000010, 1);
    check("R4 standby go", c_sgo, 1);
    check("R4 standby no reset", c_sys + c_pwr + c_bkp, 0);
    apply(7'b0000100, 1);
    check("R4 stop go", c_pgo, 1);
    check("R4 stop no reset", c_sys + c_pwr + c_bkp, 0);
    check("R4 no cause", int'(cause_flags), 0);
    @(negedge clk); opt_stdby_keep = 0; opt_stop_keep = 0;
  endtask

  task automatic t_obl();
    apply(7'b0001000, 1);
    check("R5 sys width", c_sys, 16);
    check("R5 pwr", c_pwr, 0);
    check("R10 obl flag", int'(cause_flags), 8);
    clear_flags();
  endtask

  task automatic t_pwr();
    apply(7'b0010000, 1);
    check("R6 por sys", c_sys, 16);
    check("R6 por pwr", c_pwr, 16);
    check("R6 por bkp", c_bkp, 0);
    apply(7'b0100000, 1);
    check("R6 exit sys", c_sys, 16);
    check("R6 exit pwr", c_pwr, 16);
    check("R6 exit bkp", c_bkp, 0);
    check("R10 pwr flag", int'(cause_flags), 16);
    clear_flags();
  endtask

  task automatic t_bkp_sw();
    apply(7'b1000000, 10);
    check("R7 bkp width", c_bkp, 25);
    check("R7 sys", c_sys, 0);
    check("R7 pwr", c_pwr, 0);
    check("R10 bkp flag", int'(cause_flags), 32);
    clear_flags();
  endtask

  task automatic t_supply();
    @(negedge clk); vdd_on = 0;
    repeat (6) @(negedge clk);
    fork
      vdd_on = 1;
      count_window(40);
    join
    check("R8 single rail no bkp", c_bkp, 0);
    @(negedge clk); vdd_on = 0; vbat_on = 0;
    count_window(8);
    check("R8 no bkp while off", c_bkp, 0);
    @(negedge clk);
    fork
      vbat_on = 1;
      count_window(40);
    join
    check("R8 bkp after both off", c_bkp, 16);
    check("R8 sys untouched", c_sys, 0);
    @(negedge clk); vdd_on = 1;
    count_window(20);
    check("R8 second rail no bkp", c_bkp, 0);
    clear_flags();
  endtask

  task automatic t_restart();
    @(negedge clk);
    fork
      begin
        sw_rst_req = 1; @(negedge clk); sw_rst_req = 0;
        repeat (4) @(negedge clk);
        sw_rst_req = 1; @(negedge clk); sw_rst_req = 0;
      end
      count_window(50);
    join
    check("R9 restarted width", c_sys, 21);
    clear_flags();
  endtask

  task automatic t_setwins();
    @(negedge clk); sw_rst_req = 1;
    @(negedge clk); sw_rst_req = 0;
    @(negedge clk); clr_flags = 1;
    @(negedge clk); clr_flags = 0;
    #1;
    check("R10 set wins over clear", int'(cause_flags), 1);
    repeat (25) @(posedge clk);
    clear_flags();
  endtask

  initial begin
    t_reset();
    t_sw();
    t_lp_reset();
    t_keep();
    t_obl();
    t_pwr();
    t_bkp_sw();
    t_supply();
    t_restart();
    t_setwins();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule